// File: doc/BRIEF.md
# Streaming matrix-vector multiply engine

This block multiplies a square N×N matrix of signed fixed-point words by an N×1 vector of the same format. Both operands come in over a single valid/ready word stream. The vector comes first and is held in an internal vector store. Every word after it is a matrix element, taken row by row and used straight from the stream. Each matrix element is paired with the stored vector entry for its column. One multiply-accumulate unit forms every row's dot product. Each finished row result goes into a result memory, and a simple read port drains that memory afterwards.

Software or a sequencer sets the dimension N at run time with a start pulse. Values from 2 up to the build-time maximum are valid. The engine then takes exactly N + N·N words, raises its done flag, and stalls the stream until the next start.

Top module: `mvm_engine`

## Requirements
- R1: After reset, `in_ready` is low, `done` is low and `rd_data` is zero. No input word is accepted until a start pulse arrives, even if `in_valid` is high.
- R2: A `start` pulse latches `size_n` as N, clears all counters and lowers `done`. In the following cycle `in_ready` is high.
- R3: The first N words accepted after a start are stored as vector entries 0 to N−1, in arrival order. They produce no result and do not raise `done`.
- R4: Every later accepted word is a matrix element. Row i of the result is the sum over j of A[i][j]·B[j]. The matrix streams row-major, so column j is element j within its row. All values are signed two's complement. The result width is 2·DATA_W + clog2(N_MAX) bits, and the sum is exact with no overflow.
- R5: The running sum restarts from zero at the first element of every row, so each row result does not depend on earlier rows.
- R6: The result of row i is stored at result address i, for i from 0 to N−1.
- R7: `done` rises in the cycle after the N·N-th matrix word is accepted, and it is low before that. While `done` is high, `in_ready` stays low, so extra input words are ignored. `done` stays high until the next start.
- R8: A cycle with `in_valid` low does not advance the engine. Results are the same whatever idle gaps appear in the stream.
- R9: With `rd_en` high, `rd_data` shows the result at `rd_addr` one cycle later. With `rd_en` low, `rd_data` holds its value.
- R10: N can change between operations at run time. Both the minimum of 2 and the maximum N_MAX work.
- R11: A start pulse in the middle of an operation abandons it. The new operation behaves as if it followed reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins an operation |
| size_n | input | clog2(N_MAX+1) | Matrix dimension N, sampled on start |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Engine accepts a word this cycle |
| in_data | input | DATA_W | Signed operand word, vector first, then matrix row by row |
| done | output | 1 | All N row results written |
| rd_en | input | 1 | Result read request |
| rd_addr | input | clog2(N_MAX) | Result row to read |
| rd_data | output | 2·DATA_W+clog2(N_MAX) | Signed row result, one cycle after the request |

## Verification
The assertions take three things for granted. First, `start` is a single-cycle pulse with `in_valid` low in that cycle. Second, `size_n` lies between 2 and N_MAX. Third, results are read only after `done`. The stimulus keeps to this by driving start through one task that drops `in_valid` first, and by drawing N only from that range. Random operands, random idle gaps and reads in reversed order are mixed with extreme-value operands at the largest N, the smallest N, and a restart part-way through a stream.

// File: rtl/mvm_pkg.sv
// Shared types for the matrix-vector multiply engine.
// Assumes nothing beyond being compiled first.
package mvm_pkg;

    // Phase of the engine's operation.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_VEC  = 2'd1,
        PH_MAT  = 2'd2,
        PH_DONE = 2'd3
    } mvm_phase_e;

endpackage

// File: rtl/mvm_ctrl.sv
// Sequencer: tracks phase, column and row counters and issues the write
// strobes for the vector store, the multiply-accumulate unit and the
// result memory.
// Assumes start is a single pulse and size_n lies in 2..N_MAX.
module mvm_ctrl
    import mvm_pkg::*;
#(
    parameter int N_MAX = 64,
    parameter int N_W   = $clog2(N_MAX + 1),
    parameter int A_W   = $clog2(N_MAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] size_n,
    input  logic           in_valid,
    output logic           in_ready,
    output logic [A_W-1:0] col,
    output logic [A_W-1:0] row,
    output logic           vec_we,
    output logic           mac_en,
    output logic           mac_first,
    output logic           out_we,
    output logic           done
);

    mvm_phase_e     phase;
    logic [A_W-1:0] last_idx;
    logic [N_W-1:0] size_m1;
    logic           fire;
    logic           at_last_col;

    // Decode strobes from the current phase and counters.
    always_comb begin
        size_m1     = size_n - N_W'(1);
        in_ready    = (phase == PH_VEC) || (phase == PH_MAT);
        fire        = in_valid && in_ready;
        at_last_col = (col == last_idx);
        vec_we      = fire && (phase == PH_VEC);
        mac_en      = fire && (phase == PH_MAT);
        mac_first   = (col == '0);
        out_we      = mac_en && at_last_col;
        done        = (phase == PH_DONE);
    end

    // Phase and counter update; start overrides everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            last_idx <= '0;
            col      <= '0;
            row      <= '0;
        end else if (start) begin
            phase    <= PH_VEC;
            last_idx <= size_m1[A_W-1:0];
            col      <= '0;
            row      <= '0;
        end else if (fire) begin
            if (at_last_col) begin
                col <= '0;
                if (phase == PH_VEC) begin
                    phase <= PH_MAT;
                end else begin
                    row <= row + A_W'(1);
                    if (row == last_idx) begin
                        phase <= PH_DONE;
                    end
                end
            end else begin
                col <= col + A_W'(1);
            end
        end
    end

endmodule

// File: rtl/mvm_ram.sv
// Simple one-write one-read memory. SYNC_RD selects a registered read
// (with enable, reset to zero) or a combinational read.
// Assumes addresses stay below DEPTH.
module mvm_ram #(
    parameter int WIDTH   = 16,
    parameter int DEPTH   = 64,
    parameter bit SYNC_RD = 1'b0,
    parameter int A_W     = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [A_W-1:0]          waddr,
    input  logic signed [WIDTH-1:0] wdata,
    input  logic                    re,
    input  logic [A_W-1:0]          raddr,
    output logic signed [WIDTH-1:0] rdata
);

    logic signed [WIDTH-1:0] mem [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    generate
        if (SYNC_RD) begin : g_sync
            // Registered read, held while re is low.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rdata <= '0;
                end else if (re) begin
                    rdata <= mem[raddr];
                end
            end
        end else begin : g_async
            logic unused_sync_pins;
            // Combinational read; enable and reset have no role here.
            assign unused_sync_pins = &{1'b0, re, rst_n};
            assign rdata = mem[raddr];
        end
    endgenerate

endmodule

// File: rtl/mvm_mac.sv
// Multiply-accumulate: forms the running dot product of one row.
// sum_next is the value including the current product; the register
// keeps it for the next element. Assumes ACC_W >= 2*DATA_W.
module mvm_mac #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 38
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     first,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [ACC_W-1:0]  sum_next
);

    logic signed [2*DATA_W-1:0] prod;
    logic signed [ACC_W-1:0]    acc;

    // Full-precision product added to the restarted or running sum.
    always_comb begin
        prod     = a * b;
        sum_next = (first ? '0 : acc) + ACC_W'(prod);
    end

    // Keep the running sum on each accepted matrix element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum_next;
        end
    end

endmodule

// File: rtl/mvm_engine.sv
// Streaming matrix-vector multiply engine top. Vector words are kept in a
// vector store; matrix words meet the stored entry for their column in a
// single multiply-accumulate unit; row sums land in a result memory read
// through a one-cycle port. Assumes size_n in 2..N_MAX.
module mvm_engine #(
    parameter int DATA_W = 16,
    parameter int N_MAX  = 64,
    parameter int N_W    = $clog2(N_MAX + 1),
    parameter int A_W    = $clog2(N_MAX),
    parameter int ACC_W  = 2 * DATA_W + $clog2(N_MAX)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [N_W-1:0]           size_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     done,
    input  logic                     rd_en,
    input  logic [A_W-1:0]           rd_addr,
    output logic signed [ACC_W-1:0]  rd_data
);

    logic [A_W-1:0]          col;
    logic [A_W-1:0]          row;
    logic                    vec_we;
    logic                    mac_en;
    logic                    mac_first;
    logic                    out_we;
    logic signed [DATA_W-1:0] vec_word;
    logic signed [ACC_W-1:0]  row_sum;

    mvm_ctrl #(.N_MAX(N_MAX), .N_W(N_W), .A_W(A_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .size_n(size_n),
        .in_valid(in_valid), .in_ready(in_ready), .col(col), .row(row),
        .vec_we(vec_we), .mac_en(mac_en), .mac_first(mac_first),
        .out_we(out_we), .done(done)
    );

    mvm_ram #(.WIDTH(DATA_W), .DEPTH(N_MAX), .SYNC_RD(1'b0), .A_W(A_W)) vec_ram_i (
        .clk(clk), .rst_n(rst_n), .we(vec_we), .waddr(col), .wdata(in_data),
        .re(1'b1), .raddr(col), .rdata(vec_word)
    );

    mvm_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) mac_i (
        .clk(clk), .rst_n(rst_n), .en(mac_en), .first(mac_first),
        .a(in_data), .b(vec_word), .sum_next(row_sum)
    );

    mvm_ram #(.WIDTH(ACC_W), .DEPTH(N_MAX), .SYNC_RD(1'b1), .A_W(A_W)) out_ram_i (
        .clk(clk), .rst_n(rst_n), .we(out_we), .waddr(row), .wdata(row_sum),
        .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
    );

endmodule

// File: rtl/mvm_engine_chk.sv
// Port-level properties of the engine, attached by bind below.
// Assumes start is a one-cycle pulse issued with in_valid low.
module mvm_engine_chk #(
    parameter int ACC_W = 38
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_valid,
    input logic             in_ready,
    input logic             done,
    input logic             rd_en,
    input logic [ACC_W-1:0] rd_data
);

    // While finished, no word may be taken.
    assert_done_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // Finished state persists until a new start.
    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // A start opens the stream and clears the finished flag.
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready && !done));

    // Completion only follows an accepted word.
    assert_done_after_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_valid && in_ready && !start));

    // Read data holds when no read is requested.
    assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind mvm_engine mvm_engine_chk #(.ACC_W(ACC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .done(done), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/mvm_engine_tb_top.sv
// Self-checking bench: random and directed operations, expected row sums
// computed in bench arithmetic.
module mvm_engine_tb_top;

    localparam int DATA_W = 16;
    localparam int N_MAX  = 64;
    localparam int N_W    = $clog2(N_MAX + 1);
    localparam int A_W    = $clog2(N_MAX);
    localparam int ACC_W  = 2 * DATA_W + $clog2(N_MAX);

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [N_W-1:0]           size_n = '0;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic signed [DATA_W-1:0] in_data = '0;
    logic                     done;
    logic                     rd_en = 1'b0;
    logic [A_W-1:0]           rd_addr = '0;
    logic signed [ACC_W-1:0]  rd_data;

    int     checks = 0;
    int     errors = 0;
    longint vecv [N_MAX];
    longint expv [N_MAX];

    always #4 clk = ~clk;

    mvm_engine #(.DATA_W(DATA_W), .N_MAX(N_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .size_n(size_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .done(done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0 random, 1 most negative, 2 most positive
    function automatic longint gen_word(input int mode);
        logic signed [DATA_W-1:0] t;
        if (mode == 1)      t = {1'b1, {(DATA_W-1){1'b0}}};
        else if (mode == 2) t = {1'b0, {(DATA_W-1){1'b1}}};
        else                t = DATA_W'($urandom);
        return longint'(t);
    endfunction

    task automatic do_start(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        start    = 1'b1;
        size_n   = N_W'(n);
        @(negedge clk);
        start = 1'b0;
        check(in_ready == 1'b1, "R2 ready after start", longint'(in_ready), 1);
        check(done == 1'b0, "R2 done cleared", longint'(done), 0);
    endtask

    // Feed vector then matrix; stop_after >= 0 abandons after that many words.
    task automatic stream_op(input int n, input int gap, input int mv, input int mm, input int stop_after);
        int total;
        total = n + n * n;
        for (int i = 0; i < N_MAX; i++) expv[i] = 0;
        for (int k = 0; k < total; k++) begin
            longint w;
            bit     taken;
            if (stop_after >= 0 && k == stop_after) begin
                @(negedge clk);
                in_valid = 1'b0;
                return;
            end
            if (k < n) begin
                w = gen_word(mv);
                vecv[k] = w;
            end else begin
                w = gen_word(mm);
                expv[(k - n) / n] += w * vecv[(k - n) % n];
            end
            taken = 1'b0;
            while (!taken) begin
                @(negedge clk);
                if (gap > 0 && ($urandom % 100) < gap) begin
                    in_valid = 1'b0;
                end else begin
                    in_valid = 1'b1;
                    in_data  = DATA_W'(w);
                    taken    = in_ready;
                    if (k == total - 1)
                        check(done == 1'b0, "R7 done low before last word", longint'(done), 0);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(done == 1'b1, "R7 done after last word", longint'(done), 1);
        check(in_ready == 1'b0, "R7 stalled when done", longint'(in_ready), 0);
    endtask

    task automatic read_check(input int n, input bit rev);
        longint last;
        for (int i = 0; i < n; i++) begin
            int a;
            longint got;
            a = rev ? (n - 1 - i) : i;
            @(negedge clk);
            rd_en   = 1'b1;
            rd_addr = A_W'(a);
            @(negedge clk);
            rd_en = 1'b0;
            got   = rd_data;
            last  = got;
            check(got == expv[a], "R4 R5 R6 row result", got, expv[a]);
        end
        rd_addr = '0;
        @(negedge clk);
        @(negedge clk);
        check(longint'(rd_data) == last, "R9 read data holds", longint'(rd_data), last);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(in_ready == 1'b0, "R1 ready low in reset", longint'(in_ready), 0);
        check(done == 1'b0, "R1 done low in reset", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(longint'(rd_data) == 0, "R1 read data zero", longint'(rd_data), 0);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R1 no accept before start", longint'(in_ready), 0);
        in_valid = 1'b0;

        // R10 smallest dimension
        do_start(2);
        stream_op(2, 0, 0, 0, -1);
        read_check(2, 1'b0);

        // R4 extreme operands at largest dimension (R10)
        do_start(N_MAX);
        stream_op(N_MAX, 0, 1, 1, -1);
        read_check(N_MAX, 1'b0);
        do_start(N_MAX);
        stream_op(N_MAX, 0, 2, 1, -1);
        read_check(2, 1'b1);

        // R11 abandon part-way, then a fresh operation
        do_start(7);
        stream_op(7, 20, 0, 0, 20);
        do_start(3);
        stream_op(3, 20, 0, 0, -1);
        // R7 extra words while done are ignored
        in_valid = 1'b1;
        in_data  = DATA_W'(16'h1234);
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R7 extra words ignored", longint'(in_ready), 0);
        check(done == 1'b1, "R7 done held", longint'(done), 1);
        in_valid = 1'b0;
        read_check(3, 1'b0);

        // R8 random gaps, R3 vector ordering, R10 random sizes
        for (int t = 0; t < 4; t++) begin
            int n;
            n = 2 + int'($urandom % (N_MAX - 1));
            do_start(n);
            stream_op(n, 30, 0, 0, -1);
            read_check(n, t[0]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule